// File: doc/BRIEF.md
# Selectable Eight-Step Pattern Sequencer

This block plays back one of sixteen stored timing patterns on three output lines, `t1`, `t2` and `t3`. Each pattern lasts eight clock cycles. A look-up table, given to the block as a parameter, holds one word per pattern and step. Each word names the step that follows, the three output levels and a flag that tells the block to take a new pattern number.

A select register holds the number of the pattern that is playing. A step register holds the position within that pattern. The table is addressed with the select register as the high bits and the step as the low bits. Outputs are decoded from the addressed word without a register in between.

The select register samples the `patSel` input only on a clock edge whose table word has the load flag set. With the default table that is the last step of every pattern, so patterns change only at eight-cycle boundaries. Because the table drives both the step order and the load point, a different table can give shorter loops or other switch points without any change to the logic.

Top module: `seq_pattern_top`

## Requirements
- R1: While `rstN` is low, every rising clock edge clears the step register to 0 and copies `patSel` into the select register. After release, the first cycle shows step 0 of the pattern selected during reset.
- R2: Table word layout, per entry: bits [6:4] hold the next step, bit 3 holds `t1`, bit 2 holds `t2`, bit 1 holds `t3` and bit 0 holds the load flag. Entry `{select, step}` sits at bit offset 7 × `{select, step}` of the table parameter.
- R3: On each rising edge out of reset, the step register takes the next-step field of the current word. A word with the load flag set always has a next step of 0.
- R4: On an edge where the current word's load flag is 1, the select register takes the value `patSel` has at that edge. The new pattern starts at step 0 in the following cycle.
- R5: On any edge where the load flag is 0, a change on `patSel` has no effect: the outputs continue the current pattern.
- R6: With the default table, selector 5 gives `{t1,t2,t3}` = 011, 110, 111, 100, 101, 000, 001, 000 over steps 0 to 7.
- R7: With the default table, every selector other than 5 gives `{t1,t2,t3}` = (selector + step) mod 8. In every pattern the next step is (step + 1) mod 8 and the load flag is 1 only at step 7.
- R8: The block follows a table supplied as a parameter. With a table whose patterns loop over steps 0 to 3, with the load flag at step 3 and outputs equal to selector[2:0] XOR step, the block repeats every four cycles and changes selector every four cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous reset, active low |
| patSel | input | 4 | Pattern number, taken only on load edges and during reset |
| t1 | output | 1 | First timing output, bit 3 of the current word |
| t2 | output | 1 | Second timing output, bit 2 of the current word |
| t3 | output | 1 | Third timing output, bit 1 of the current word |

## Verification
A corrupted step register shows in the same cycle: the outputs take a value from the wrong row of the pattern, and every later step stays out of phase. A select register that loads at the wrong time, or misses a load, shows at the first output step after the missed or spurious edge. The error then persists for at least a whole pattern. The bench predicts both registers from the port stimulus alone and compares all three outputs in every cycle. It uses the default table and a four-step custom table, so that the next-step field and the load field are each tested away from their default values.

// File: rtl/seq_pattern_pkg.sv
package seq_pattern_pkg;

  localparam int SEL_W_DEF   = 4;
  localparam int STEP_W_DEF  = 3;
  localparam int WORD_W_DEF  = STEP_W_DEF + 4;
  localparam int DEPTH_DEF   = 2 ** (SEL_W_DEF + STEP_W_DEF);
  localparam int TABLE_W_DEF = DEPTH_DEF * WORD_W_DEF;
  localparam int STEPS_DEF   = 2 ** STEP_W_DEF;

  localparam logic [SEL_W_DEF-1:0] SPECIAL_SEL = SEL_W_DEF'(5);

  // strobes passed from control to datapath
  typedef struct packed {
    logic captureSel;
    logic holdStep;
  } seqStrobes_t;

  function automatic logic [2:0] specialOuts(input int st);
    logic [2:0] v;
    case (st)
      0: v = 3'b011;
      1: v = 3'b110;
      2: v = 3'b111;
      3: v = 3'b100;
      4: v = 3'b101;
      5: v = 3'b000;
      6: v = 3'b001;
      default: v = 3'b000;
    endcase
    return v;
  endfunction

  function automatic logic [TABLE_W_DEF-1:0] defaultTable();
    logic [TABLE_W_DEF-1:0] tab;
    tab = '0;
    for (int idx = 0; idx < DEPTH_DEF; idx++) begin
      int selV;
      int stV;
      logic [STEP_W_DEF-1:0] nxt;
      logic [2:0] outs;
      logic ld;
      selV = idx / STEPS_DEF;
      stV  = idx % STEPS_DEF;
      nxt  = STEP_W_DEF'((stV + 1) % STEPS_DEF);
      if (selV == int'(SPECIAL_SEL)) outs = specialOuts(stV);
      else outs = 3'((selV + stV) % 8);
      ld = (stV == STEPS_DEF - 1);
      tab[idx*WORD_W_DEF +: WORD_W_DEF] = {nxt, outs, ld};
    end
    return tab;
  endfunction

endpackage

// File: rtl/seq_pattern_ctrl.sv
module seq_pattern_ctrl
  import seq_pattern_pkg::*;
#(
  parameter int STEP_W = STEP_W_DEF,
  localparam int WORD_W = STEP_W + 4
) (
  input  logic [WORD_W-1:0] curWord,
  output logic [STEP_W-1:0] nextStep,
  output logic              loadFlag,
  output logic [2:0]        outBits,
  output seqStrobes_t       strobes
);

  // split the table word into its fields
  always_comb begin
    nextStep = curWord[WORD_W-1 -: STEP_W];
    outBits  = curWord[3:1];
    loadFlag = curWord[0];
  end

  // the load flag is the only trigger for a selector capture
  always_comb begin
    strobes.captureSel = loadFlag;
    strobes.holdStep   = 1'b0;
  end

endmodule

// File: rtl/seq_pattern_dp.sv
module seq_pattern_dp
  import seq_pattern_pkg::*;
#(
  parameter int SEL_W  = SEL_W_DEF,
  parameter int STEP_W = STEP_W_DEF,
  localparam int WORD_W  = STEP_W + 4,
  localparam int ADDR_W  = SEL_W + STEP_W,
  localparam int DEPTH   = 2 ** ADDR_W,
  localparam int TABLE_W = DEPTH * WORD_W,
  parameter logic [TABLE_W-1:0] PAT_TABLE = defaultTable()
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SEL_W-1:0]  patSel,
  input  logic [STEP_W-1:0] nextStep,
  input  seqStrobes_t       strobes,
  output logic [SEL_W-1:0]  selQ,
  output logic [STEP_W-1:0] stepQ,
  output logic [WORD_W-1:0] curWord
);

  logic [WORD_W-1:0] romArr [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_rom
    assign romArr[gi] = PAT_TABLE[gi*WORD_W +: WORD_W];
  end

  assign curWord = romArr[{selQ, stepQ}];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepQ <= '0;
      selQ  <= patSel;
    end else begin
      if (!strobes.holdStep) stepQ <= nextStep;
      if (strobes.captureSel) selQ <= patSel;
    end
  end

endmodule

// File: rtl/seq_pattern_top.sv
module seq_pattern_top
  import seq_pattern_pkg::*;
#(
  parameter int SEL_W  = SEL_W_DEF,
  parameter int STEP_W = STEP_W_DEF,
  localparam int WORD_W  = STEP_W + 4,
  localparam int TABLE_W = (2 ** (SEL_W + STEP_W)) * WORD_W,
  parameter logic [TABLE_W-1:0] PAT_TABLE = defaultTable()
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] patSel,
  output logic             t1,
  output logic             t2,
  output logic             t3
);

  logic [SEL_W-1:0]  selQ;
  logic [STEP_W-1:0] stepQ;
  logic [WORD_W-1:0] curWord;
  logic [STEP_W-1:0] nextStep;
  logic              loadFlag;
  logic [2:0]        outBits;
  seqStrobes_t       strobes;

  seq_pattern_ctrl #(.STEP_W(STEP_W)) u_ctrl (
    .curWord  (curWord),
    .nextStep (nextStep),
    .loadFlag (loadFlag),
    .outBits  (outBits),
    .strobes  (strobes)
  );

  seq_pattern_dp #(
    .SEL_W(SEL_W), .STEP_W(STEP_W), .PAT_TABLE(PAT_TABLE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .patSel   (patSel),
    .nextStep (nextStep),
    .strobes  (strobes),
    .selQ     (selQ),
    .stepQ    (stepQ),
    .curWord  (curWord)
  );

  assign {t1, t2, t3} = outBits;

endmodule

// File: rtl/seq_pattern_chk.sv
module seq_pattern_chk #(
  parameter int SEL_W  = 4,
  parameter int STEP_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [SEL_W-1:0]  patSel,
  input logic [SEL_W-1:0]  selQ,
  input logic [STEP_W-1:0] stepQ,
  input logic [STEP_W-1:0] nextStep,
  input logic              loadFlag,
  input logic              t1,
  input logic              t2,
  input logic              t3
);

  logic armed;
  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else armed <= 1'b1;
  end

  // R1: reset leaves step zero and the selector equal to the input
  p_reset_state_r1: assert property (@(posedge clk)
    !rstN |=> (stepQ == '0) && (selQ == $past(patSel)));

  // R3: step register follows the next-step field
  p_step_follow_r3: assert property (@(posedge clk) disable iff (!rstN || !armed)
    1'b1 |-> stepQ == $past(nextStep));

  // R3: a load word always returns to step zero
  p_load_wraps_r3: assert property (@(posedge clk) disable iff (!rstN)
    loadFlag |-> nextStep == '0);

  // R4: a load edge captures the selector input
  p_load_capture_r4: assert property (@(posedge clk) disable iff (!rstN || !armed)
    $past(loadFlag) |-> selQ == $past(patSel));

  // R5: without a load edge the selector holds
  p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rstN || !armed)
    !$past(loadFlag) |-> $stable(selQ));

  // R2: outputs are always driven to known levels
  p_outs_known_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown({t1, t2, t3}));

endmodule

bind seq_pattern_top seq_pattern_chk #(.SEL_W(SEL_W), .STEP_W(STEP_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .patSel   (patSel),
  .selQ     (selQ),
  .stepQ    (stepQ),
  .nextStep (nextStep),
  .loadFlag (loadFlag),
  .t1       (t1),
  .t2       (t2),
  .t3       (t3)
);

// File: tb/seq_pattern_top_tb.sv
module seq_pattern_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TAB_W = 128 * 7;

  // four-step table: next = (step+1)%4, load at step 3, outs = sel[2:0]^step
  function automatic logic [TAB_W-1:0] shortTable();
    logic [TAB_W-1:0] tab;
    tab = '0;
    for (int i = 0; i < 128; i++) begin
      int s;
      int st;
      s  = i / 8;
      st = i % 8;
      if (st < 4)
        tab[i*7 +: 7] = {3'((st + 1) % 4), 3'(s[2:0] ^ st[2:0]), (st == 3)};
      else
        tab[i*7 +: 7] = {3'd0, 3'd0, 1'b1};
    end
    return tab;
  endfunction

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] patSel = 4'd5;
  logic a1, a2, a3, b1, b2, b3;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  int m1Sel, m1Step, m2Sel, m2Step;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_pattern_top u_dut (
    .clk(clk), .rstN(rstN), .patSel(patSel), .t1(a1), .t2(a2), .t3(a3)
  );

  seq_pattern_top #(.PAT_TABLE(shortTable())) u_dut_short (
    .clk(clk), .rstN(rstN), .patSel(patSel), .t1(b1), .t2(b2), .t3(b3)
  );

  function automatic logic [2:0] expSpecial(input int st);
    case (st)
      0: return 3'b011;
      1: return 3'b110;
      2: return 3'b111;
      3: return 3'b100;
      4: return 3'b101;
      5: return 3'b000;
      6: return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [2:0] expDefault(input int s, input int st);
    if (s == 5) return expSpecial(st);
    return 3'((s + st) % 8);
  endfunction

  function automatic logic [2:0] expShort(input int s, input int st);
    return 3'(s[2:0] ^ st[2:0]);
  endfunction

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  // check both instances now, then advance the models across the next edge
  task automatic cyc(input string reqMain, input string reqShort);
    #1;
    check(reqMain, {a1, a2, a3}, expDefault(m1Sel, m1Step));
    check(reqShort, {b1, b2, b3}, expShort(m2Sel, m2Step));
    if (m1Step == 7) m1Sel = int'(patSel);
    m1Step = (m1Step + 1) % 8;
    if (m2Step == 3) m2Sel = int'(patSel);
    m2Step = (m2Step + 1) % 4;
    @(negedge clk);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    patSel = 4'd5;
    repeat (3) @(negedge clk);
    #1;
    check("R1", {a1, a2, a3}, 3'b011);
    patSel = 4'd9;
    @(negedge clk);
    #1;
    check("R1", {a1, a2, a3}, expDefault(9, 0));
    check("R1", {b1, b2, b3}, expShort(9, 0));
    @(negedge clk);
    rstN = 1'b1;
    m1Sel = 9; m1Step = 0; m2Sel = 9; m2Step = 0;
  endtask

  task automatic testSpecial();
    patSel = 4'd5;
    for (int k = 0; k < 8; k++) cyc("R7", "R8");
    for (int k = 0; k < 8; k++) cyc("R6", "R8");
  endtask

  task automatic testSweep();
    for (int s = 0; s < 16; s++) begin
      patSel = 4'(s);
      for (int k = 0; k < 8; k++) cyc("R4", "R8");
    end
  endtask

  task automatic testMidChange();
    for (int k = 0; k < 24; k++) begin
      patSel = 4'((k * 7 + 3) % 16);
      cyc("R5", "R8");
    end
  endtask

  task automatic testStepOrder();
    patSel = 4'd12;
    for (int k = 0; k < 16; k++) cyc("R3", "R8");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    testReset();
    testSpecial();
    testSweep();
    testMidChange();
    testStepOrder();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule